// File: doc/BRIEF.md
# Line-Change Timestamp Engine

The engine watches a parameterised bank of asynchronous input lines. Each line passes through a synchroniser, and every change of level on a line, rising or falling, is detected. When the line is enabled, the change is recorded together with the value of an externally supplied 64-bit free-running counter. Each record holds the counter value, the index of the line and the level the line changed to. Records are queued in an on-chip FIFO, and software drains them one at a time through a small word-addressed register port.

Software turns lines on and off through an enable bitmap. The bitmap is split into 32-bit slices, and slice k covers lines 32k to 32k+31. A level-sensitive interrupt indicates that the FIFO holds at least a programmable number of records. When the queue is full, new records are dropped and a sticky overflow flag is raised.

Top module: `line_stamp_engine`

## Requirements
- R1: A level change on an enabled line, in either direction, produces one record. The record's stamp is the counter value present at the third rising clock edge after the line changes, and its level field is the new line level.
- R2: Enable slice k is read and written at word address 0x40+k. Bit j of that slice enables line 32k+j. A change on a disabled line leaves the FIFO empty.
- R3: When several enabled lines change in the same cycle, their records enter the FIFO one per cycle in ascending line order, and all of them carry the same stamp.
- R4: A read of address 0x02 pops the head record and returns bit 31 = level, bit 30 = 1 (valid) and bits 15:0 = line index. Addresses 0x03 and 0x04 then return the low and high 32 bits of that record's stamp.
- R5: A read of address 0x02 while the FIFO is empty returns zero, leaves the count at zero, and makes 0x03 and 0x04 read zero.
- R6: The threshold register at address 0x00 resets to 1. A write of 0 stores 1, a write above 256 stores 256, and any other value is stored as written.
- R7: The interrupt output, which is mirrored in STATUS bit 0, is high exactly while the entry count is at least the threshold. It falls as soon as a pop takes the count below the threshold.
- R8: A record that arrives while the FIFO is full is dropped and sets the sticky overflow flag, STATUS bit 1. Writing 1 to STATUS bit 1 clears the flag. STATUS at address 0x01 also reports empty in bit 2 and the count in bits 24:16.
- R9: Records leave the FIFO in arrival order, and the FIFO holds as many records as its depth parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | NUM_SLICES*32 | Monitored asynchronous lines |
| sysTime | input | TS_WIDTH | Free-running system counter |
| addr | input | ADDR_WIDTH | Register word address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdEn | input | 1 | Register read strobe (pops on address 0x02) |
| rdData | output | 32 | Register read data, combinational on addr |
| irq | output | 1 | Threshold interrupt, level-sensitive |

## Verification
The bench builds the engine with its default values: three slices, which give 96 lines, and a FIFO depth of 256. At these values every slice boundary can be reached, and lines 32, 69 and 95 fall in the upper slices. The full depth is also reachable, so the bench can fill the FIFO exactly to the largest threshold and then push one record past it to reach overflow. The counter starts just below a 32-bit boundary, so the high stamp word is exercised as it crosses.

// File: rtl/lse_pkg.sv
package lse_pkg;

  typedef struct packed {
    logic pop;
    logic clearOvf;
  } ctrlStrobes_t;

endpackage

// File: rtl/lse_fifo.sv
module lse_fifo #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && full && !popEn) |=> (count == $past(count))); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && empty && !pushEn) |=> (count == '0)); // R5

endmodule

// File: rtl/lse_datapath.sv
module lse_datapath
  import lse_pkg::*;
#(
  parameter int NUM_LINES  = 96,
  parameter int FIFO_DEPTH = 256,
  parameter int TS_WIDTH   = 64,
  parameter int IDX_W      = 7,
  parameter int CNT_W      = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [NUM_LINES-1:0] lineEnable,
  input  logic [TS_WIDTH-1:0]  sysTime,
  input  ctrlStrobes_t         strobes,
  output logic [TS_WIDTH-1:0]  headStamp,
  output logic [IDX_W-1:0]     headIdx,
  output logic                 headLvl,
  output logic [CNT_W-1:0]     fifoCount,
  output logic                 fifoEmpty,
  output logic                 dropPulse
);

  localparam int ENTRY_W = TS_WIDTH + IDX_W + 1;

  logic [NUM_LINES-1:0] syncA, syncB, lastLvl, pending, heldLvl;
  logic [NUM_LINES-1:0] edgeHit, pendClr;
  logic [TS_WIDTH-1:0]  lineStamp [NUM_LINES];
  logic [2:0]           primeSr;
  logic [IDX_W-1:0]     grantIdx;
  logic                 anyPend, fifoFull;
  logic [ENTRY_W-1:0]   pushData, headData;

  // Edges count only once the synchroniser and history flops hold real samples
  assign edgeHit = (syncB ^ lastLvl) & lineEnable & {NUM_LINES{primeSr[2]}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      lastLvl <= '0;
      primeSr <= '0;
      pending <= '0;
      heldLvl <= '0;
    end else begin
      syncA   <= lineIn;
      syncB   <= syncA;
      lastLvl <= syncB;
      primeSr <= {primeSr[1:0], 1'b1};
      pending <= (pending & ~pendClr) | edgeHit;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (edgeHit[i]) heldLvl[i] <= syncB[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (edgeHit[i]) lineStamp[i] <= sysTime;
    end
  end

  // Lowest pending index wins
  always_comb begin
    grantIdx = '0;
    anyPend  = |pending;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pending[i]) grantIdx = IDX_W'(i);
    end
  end

  assign pendClr   = anyPend ? (NUM_LINES'(1) << grantIdx) : '0;
  assign pushData  = {lineStamp[grantIdx], grantIdx, heldLvl[grantIdx]};
  assign dropPulse = anyPend && fifoFull;

  lse_fifo #(
    .WIDTH (ENTRY_W),
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
  ) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (anyPend),
    .pushData (pushData),
    .popEn    (strobes.pop),
    .headData (headData),
    .count    (fifoCount),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  assign headStamp = headData[ENTRY_W-1 -: TS_WIDTH];
  assign headIdx   = headData[IDX_W:1];
  assign headLvl   = headData[0];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendClr)); // R3

  AST_GRANT_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (anyPend && !fifoFull && !strobes.pop) |=> (fifoCount == $past(fifoCount) + 1'b1)); // R9

endmodule

// File: rtl/lse_control.sv
module lse_control
  import lse_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  parameter int ADDR_WIDTH = 8,
  parameter int TS_WIDTH   = 64,
  parameter int IDX_W      = 7,
  parameter int CNT_W      = 9,
  parameter int THR_MAX    = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_WIDTH-1:0]    addr,
  input  logic                     wrEn,
  input  logic [31:0]              wrData,
  input  logic                     rdEn,
  output logic [31:0]              rdData,
  output logic                     irq,
  output logic [NUM_SLICES*32-1:0] lineEnable,
  output ctrlStrobes_t             strobes,
  input  logic [TS_WIDTH-1:0]      headStamp,
  input  logic [IDX_W-1:0]         headIdx,
  input  logic                     headLvl,
  input  logic [CNT_W-1:0]         fifoCount,
  input  logic                     fifoEmpty,
  input  logic                     dropPulse
);

  localparam int THR_W = $clog2(THR_MAX + 1);
  localparam int SEL_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
  localparam logic [ADDR_WIDTH-1:0] A_THRESH = ADDR_WIDTH'(8'h00);
  localparam logic [ADDR_WIDTH-1:0] A_STATUS = ADDR_WIDTH'(8'h01);
  localparam logic [ADDR_WIDTH-1:0] A_POP    = ADDR_WIDTH'(8'h02);
  localparam logic [ADDR_WIDTH-1:0] A_TSLO   = ADDR_WIDTH'(8'h03);
  localparam logic [ADDR_WIDTH-1:0] A_TSHI   = ADDR_WIDTH'(8'h04);
  localparam logic [ADDR_WIDTH-1:0] A_ENBASE = ADDR_WIDTH'(8'h40);

  logic [THR_W-1:0] thresh;
  logic             ovfSticky;
  logic [63:0]      tsHold;
  logic [31:0]      enSlice [NUM_SLICES];
  logic             enHit;
  logic [SEL_W-1:0] sliceSel;
  logic [31:0]      popWord;

  assign enHit    = (addr >= A_ENBASE) && (addr < A_ENBASE + ADDR_WIDTH'(NUM_SLICES));
  assign sliceSel = SEL_W'(addr - A_ENBASE);

  assign strobes.pop      = rdEn && (addr == A_POP) && !fifoEmpty;
  assign strobes.clearOvf = wrEn && (addr == A_STATUS) && wrData[1];

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    always_ff @(posedge clk) begin
      if (!rstN) enSlice[k] <= '0;
      else if (wrEn && enHit && (sliceSel == SEL_W'(k))) enSlice[k] <= wrData;
    end
    assign lineEnable[k*32 +: 32] = enSlice[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thresh    <= THR_W'(1);
      ovfSticky <= 1'b0;
      tsHold    <= '0;
    end else begin
      if (wrEn && addr == A_THRESH) begin
        if (wrData == '0)                 thresh <= THR_W'(1);
        else if (wrData > 32'(THR_MAX))   thresh <= THR_W'(THR_MAX);
        else                              thresh <= THR_W'(wrData);
      end
      if (dropPulse)             ovfSticky <= 1'b1;
      else if (strobes.clearOvf) ovfSticky <= 1'b0;
      if (rdEn && addr == A_POP) tsHold <= fifoEmpty ? '0 : 64'(headStamp);
    end
  end

  assign irq = ({1'b0, fifoCount} >= (CNT_W+1)'(thresh));

  always_comb begin
    popWord = '0;
    if (!fifoEmpty) begin
      popWord[31]   = headLvl;
      popWord[30]   = 1'b1;
      popWord[15:0] = 16'(headIdx);
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == A_THRESH)      rdData = 32'(thresh);
    else if (addr == A_STATUS) rdData = {7'b0, 9'(fifoCount), 13'b0, fifoEmpty, ovfSticky, irq};
    else if (addr == A_POP)    rdData = popWord;
    else if (addr == A_TSLO)   rdData = tsHold[31:0];
    else if (addr == A_TSHI)   rdData = tsHold[63:32];
    else if (enHit)            rdData = enSlice[sliceSel];
  end

  AST_THRESH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (thresh >= THR_W'(1)) && (thresh <= THR_W'(THR_MAX))); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |=> ovfSticky); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfSticky && !strobes.clearOvf) |=> ovfSticky); // R8

endmodule

// File: rtl/line_stamp_engine.sv
module line_stamp_engine
  import lse_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  parameter int FIFO_DEPTH = 256,
  parameter int TS_WIDTH   = 64,
  parameter int ADDR_WIDTH = 8,
  parameter int THR_MAX    = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SLICES*32-1:0] lineIn,
  input  logic [TS_WIDTH-1:0]      sysTime,
  input  logic [ADDR_WIDTH-1:0]    addr,
  input  logic                     wrEn,
  input  logic [31:0]              wrData,
  input  logic                     rdEn,
  output logic [31:0]              rdData,
  output logic                     irq
);

  localparam int NUM_LINES = NUM_SLICES * 32;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);

  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] lineEnable;
  logic [TS_WIDTH-1:0]  headStamp;
  logic [IDX_W-1:0]     headIdx;
  logic                 headLvl, fifoEmpty, dropPulse;
  logic [CNT_W-1:0]     fifoCount;

  lse_control #(
    .NUM_SLICES (NUM_SLICES),
    .ADDR_WIDTH (ADDR_WIDTH),
    .TS_WIDTH   (TS_WIDTH),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .THR_MAX    (THR_MAX)
  ) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdEn       (rdEn),
    .rdData     (rdData),
    .irq        (irq),
    .lineEnable (lineEnable),
    .strobes    (strobes),
    .headStamp  (headStamp),
    .headIdx    (headIdx),
    .headLvl    (headLvl),
    .fifoCount  (fifoCount),
    .fifoEmpty  (fifoEmpty),
    .dropPulse  (dropPulse)
  );

  lse_datapath #(
    .NUM_LINES  (NUM_LINES),
    .FIFO_DEPTH (FIFO_DEPTH),
    .TS_WIDTH   (TS_WIDTH),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .lineEnable (lineEnable),
    .sysTime    (sysTime),
    .strobes    (strobes),
    .headStamp  (headStamp),
    .headIdx    (headIdx),
    .headLvl    (headLvl),
    .fifoCount  (fifoCount),
    .fifoEmpty  (fifoEmpty),
    .dropPulse  (dropPulse)
  );

endmodule

// File: tb/test_line_stamp_engine.sv
module test_line_stamp_engine;

  localparam int NS = 3;
  localparam int NL = NS * 32;
  localparam int DEPTH = 256;

  typedef struct packed {
    logic [63:0] ts;
    logic [15:0] idx;
    logic        lvl;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] lineIn = '0;
  logic [63:0]   sysTime = 64'h0000_0000_FFFF_FF00;
  logic [7:0]    addr = '0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic [31:0]   rdData;
  logic          irq;

  int checks = 0;
  int fails = 0;
  exp_t expQ[$];
  logic [NL-1:0] enShadow = '0;
  bit doneFlag = 0;

  always #5 clk = ~clk;
  always @(posedge clk) sysTime <= sysTime + 1;

  line_stamp_engine i_line_stamp_engine (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .sysTime(sysTime),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] statusWord(input int cnt, input bit ovf, input bit irqv);
    return {7'b0, 9'(cnt), 13'b0, (cnt == 0), ovf, irqv};
  endfunction

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  // Driver: toggles lines and records the expected records in the scoreboard
  task automatic changeLines(input logic [NL-1:0] mask);
    logic [63:0] s;
    int n = 0;
    @(negedge clk);
    s = sysTime;
    lineIn = lineIn ^ mask;
    for (int i = 0; i < NL; i++) begin
      if (mask[i] && enShadow[i]) begin
        n++;
        if (expQ.size() < DEPTH) expQ.push_back('{ts: s + 64'd2, idx: 16'(i), lvl: lineIn[i]});
      end
    end
    repeat (n + 4) @(negedge clk);
  endtask

  // Monitor: pops one record and compares it with the scoreboard head
  task automatic popCompare(input string req);
    logic [31:0] d, lo, hi;
    exp_t e;
    readReg(8'h02, d);
    readReg(8'h03, lo);
    readReg(8'h04, hi);
    if (expQ.size() == 0) begin
      check(d == 0, req, d, 0);
    end else begin
      e = expQ.pop_front();
      check(d == {e.lvl, 1'b1, 14'b0, e.idx}, {req, " entry"}, d, {e.lvl, 1'b1, 14'b0, e.idx});
      check({hi, lo} == e.ts, {req, " stamp"}, {hi, lo}, e.ts);
    end
  endtask

  task automatic drain(input string req);
    while (expQ.size() > 0) popCompare(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // Reset state
    readReg(8'h01, d);
    check(d == statusWord(0, 0, 0), "R8 reset status", d, statusWord(0, 0, 0));
    check(irq == 1'b0, "R7 reset irq", irq, 0);
    readReg(8'h00, d);
    check(d == 32'd1, "R6 reset threshold", d, 1);

    // Disabled line change is ignored
    changeLines(NL'(1) << 5);
    readReg(8'h01, d);
    check(d == statusWord(0, 0, 0), "R2 disabled line", d, statusWord(0, 0, 0));

    // Enable slices and read them back
    writeReg(8'h40, 32'h0000_0028);
    writeReg(8'h41, 32'h0000_0001);
    writeReg(8'h42, 32'h8000_0020);
    enShadow = '0;
    enShadow[3] = 1; enShadow[5] = 1; enShadow[32] = 1; enShadow[69] = 1; enShadow[95] = 1;
    readReg(8'h40, d); check(d == 32'h0000_0028, "R2 slice0 readback", d, 32'h28);
    readReg(8'h41, d); check(d == 32'h0000_0001, "R2 slice1 readback", d, 32'h1);
    readReg(8'h42, d); check(d == 32'h8000_0020, "R2 slice2 readback", d, 32'h8000_0020);

    // Simultaneous changes, one disabled line mixed in
    begin
      logic [NL-1:0] m = '0;
      m[95] = 1; m[3] = 1; m[69] = 1; m[32] = 1; m[7] = 1;
      changeLines(m);
    end
    readReg(8'h01, d);
    check(d == statusWord(4, 0, 1), "R3 four records queued", d, statusWord(4, 0, 1));
    check(irq == 1'b1, "R7 irq at threshold 1", irq, 1);
    drain("R3");
    check(irq == 1'b0, "R7 irq after drain", irq, 0);

    // Both edge directions on one line
    changeLines(NL'(1) << 5);
    changeLines(NL'(1) << 5);
    drain("R1");

    // Empty pop
    popCompare("R5 empty pop");
    readReg(8'h03, d); check(d == 0, "R5 stamp low after empty pop", d, 0);
    readReg(8'h04, d); check(d == 0, "R5 stamp high after empty pop", d, 0);
    readReg(8'h01, d); check(d == statusWord(0, 0, 0), "R5 count stays zero", d, statusWord(0, 0, 0));

    // Threshold behaviour
    writeReg(8'h00, 32'd3);
    readReg(8'h00, d); check(d == 32'd3, "R6 threshold 3", d, 3);
    changeLines(NL'(1) << 3);
    changeLines(NL'(1) << 3);
    check(irq == 1'b0, "R7 below threshold", irq, 0);
    changeLines(NL'(1) << 3);
    check(irq == 1'b1, "R7 at threshold", irq, 1);
    popCompare("R4");
    check(irq == 1'b0, "R7 falls after pop", irq, 0);
    drain("R4");

    // Threshold clamping
    writeReg(8'h00, 32'd0);
    readReg(8'h00, d); check(d == 32'd1, "R6 zero clamps to 1", d, 1);
    writeReg(8'h00, 32'd300);
    readReg(8'h00, d); check(d == 32'd256, "R6 large clamps to 256", d, 256);

    // Fill to depth, then overflow
    for (int k = 0; k < DEPTH - 1; k++) changeLines(NL'(1) << 32);
    readReg(8'h01, d);
    check(d == statusWord(DEPTH - 1, 0, 0), "R7 count 255 below 256", d, statusWord(DEPTH - 1, 0, 0));
    changeLines(NL'(1) << 32);
    readReg(8'h01, d);
    check(d == statusWord(DEPTH, 0, 1), "R9 full at depth", d, statusWord(DEPTH, 0, 1));
    changeLines(NL'(1) << 32);
    readReg(8'h01, d);
    check(d == statusWord(DEPTH, 1, 1), "R8 overflow flagged", d, statusWord(DEPTH, 1, 1));
    writeReg(8'h01, 32'h0000_0002);
    readReg(8'h01, d);
    check(d == statusWord(DEPTH, 0, 1), "R8 overflow cleared", d, statusWord(DEPTH, 0, 1));
    drain("R9");
    readReg(8'h01, d);
    check(d == statusWord(0, 0, 0), "R9 empty after drain", d, statusWord(0, 0, 0));

    doneFlag = 1;
    finishRun();
  end

endmodule